// File: doc/BRIEF.md
# Dual Edge Event Counter with Stretched Interrupt

This block watches two external event lines and keeps a 16-bit count for each one. Each line is first brought into the clock domain through a two-flop synchronizer. An edge is then found by comparing the newest synchronized sample with the one before it. Each channel has its own polarity bit, so one channel can count rising transitions while the other counts falling ones. Every counted edge, on either channel, drives a shared active-low interrupt low. The interrupt stays low until a set number of timebase ticks has passed since the most recent event.

A small byte-wide register port lets the host set the polarities, clear both counts and read them. Reading a channel's low byte also captures that channel's upper byte into a snapshot. The following high-byte read therefore gives a value that matches the low byte, even if the counter moves between the two reads.

The counters keep their value across the system reset, because in the target system they live in a domain that outlasts the main supply. Only the host clear bit zeroes them.

Top module: `edge_event_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the block does the following at that edge: `irq_n` goes to 1, `reg_rdata` goes to 0, both polarity bits go to 0 (rising), and both snapshots go to 0.
- R2: The synchronizer and edge detector add a fixed latency. A change on `evt_in[i]` that is present at clock edge k is counted at edge k+2. A read issued at edge k+3 or later returns the new count.
- R3: The control register is at address 0. Bit i (0 for channel 0, 1 for channel 1) selects falling-edge counting when it is 1 and rising-edge counting when it is 0. Edges of the other polarity are not counted. A write to address 0 stores bits 1:0. A read of address 0 returns the polarity bits in bits 1:0 and zeros elsewhere.
- R4: A counter at FFFFh that sees a counted edge becomes 0000h.
- R5: A counted edge on either channel sets `irq_n` to 0 at the same clock edge at which the count changes. `irq_n` returns to 1 at the clock edge that samples the STRETCH_TICKS-th `tick` pulse after that event. A tick sampled at the event edge itself does not count.
- R6: A counted edge that arrives while `irq_n` is low restarts the tick count, so the pulse is extended.
- R7: Writing address 0 with bit 7 set zeroes both counters at that clock edge. If an edge falls in the same cycle, the clear wins and the counter reads 0. That edge still starts the interrupt pulse.
- R8: Reading a channel's low byte captures the counter's upper byte at the same edge. A later read of the high byte returns that captured value, not the live upper byte.
- R9: The system reset leaves the counters unchanged.
- R10: The two channels count independently. An edge on one channel never changes the other channel's count.
- R11: `reg_rdata` is loaded at the clock edge that samples `reg_rd` and holds its value when `reg_rd` is low. The addresses are: 1 for channel 0 low byte, 2 for channel 0 high byte, 3 for channel 1 low byte and 4 for channel 1 high byte. Any other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset (does not touch the counters) |
| evt_in | input | NUM_CH (2) | Asynchronous event lines, one per channel |
| tick | input | 1 | One-cycle timebase pulse that measures the interrupt stretch |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low stretched event interrupt |

## Verification
The clear command and a counted edge can land on the same clock edge. The bench forces this by raising a channel's input exactly two cycles before it issues the clear write. It then expects a zero count together with a low interrupt. A low-byte read can also coincide with, or be followed by, a carry into the upper byte. The bench reads the low byte at FFh, adds more edges and checks that the high-byte read still returns the captured upper byte. A cycle-level reference model in the bench predicts `irq_n` and `reg_rdata` on every clock, and that includes these collisions.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int BYTE_W  = 8;
  localparam int CLR_BIT = 7;

  // address of a channel's low byte; the upper bytes follow it
  function automatic int lo_addr(input int ch, input int bytes);
    return 1 + ch * bytes;
  endfunction
endpackage

// File: rtl/evc_edge_sync.sv
module evc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic fall_sel,
  output logic evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      prev_q <= cur;
    end
  end

  always_comb begin
    evt = fall_sel ? (prev_q & ~cur) : (~prev_q & cur);
  end

  // R3
  edge_gap_chk: assert property (@(posedge clk) disable iff (rst)
    evt ##1 $stable(fall_sel) |-> !evt);
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  // no system reset: state must outlive the main supply
  always_ff @(posedge clk) begin
    if (clr)
      count <= '0;
    else if (inc)
      count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/evc_irq_stretch.sv
module evc_irq_stretch #(
  parameter int TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic tick,
  output logic irq_n
);
  localparam int TMR_W = $clog2(TICKS + 1);

  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    tmr_d = tmr_q;
    if (trig)
      tmr_d = TMR_W'(TICKS);
    else if (tick && tmr_q != '0)
      tmr_d = tmr_q - TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
      irq_n <= 1'b1;
    end else begin
      tmr_q <= tmr_d;
      irq_n <= (tmr_d == '0);
    end
  end

  // R5
  irq_assert_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> !irq_n);
  // R5
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> $past(tick));
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !tick) |=> !irq_n);
endmodule

// File: rtl/evc_regif.sv
module evc_regif
  import evc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wr,
  input  logic                         rd,
  input  logic [BYTE_W-1:0]            wdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec,
  output logic [BYTE_W-1:0]            rdata,
  output logic [NUM_CH-1:0]            fall_sel,
  output logic                         clr
);
  localparam int BYTES  = CNT_W / BYTE_W;
  localparam int SNAP_W = CNT_W - BYTE_W;

  logic [NUM_CH-1:0][SNAP_W-1:0] snap_q;
  logic [NUM_CH-1:0]             snap_ld;
  logic [BYTE_W-1:0]             rd_nxt;
  logic                          ctrl_sel;

  assign ctrl_sel = (addr == ADDR_W'(0));
  assign clr      = wr && !rst && ctrl_sel && wdata[CLR_BIT];

  always_comb begin
    rd_nxt  = '0;
    snap_ld = '0;
    if (ctrl_sel)
      rd_nxt[NUM_CH-1:0] = fall_sel;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr == ADDR_W'(lo_addr(ch, BYTES))) begin
        rd_nxt      = cnt_vec[ch][BYTE_W-1:0];
        snap_ld[ch] = 1'b1;
      end
      for (int b = 1; b < BYTES; b++) begin
        if (addr == ADDR_W'(lo_addr(ch, BYTES) + b))
          rd_nxt = snap_q[ch][(b-1)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      fall_sel <= '0;
      snap_q   <= '0;
    end else begin
      if (rd) begin
        rdata <= rd_nxt;
        for (int ch = 0; ch < NUM_CH; ch++)
          if (snap_ld[ch])
            snap_q[ch] <= cnt_vec[ch][CNT_W-1:BYTE_W];
      end
      if (wr && ctrl_sel)
        fall_sel <= wdata[NUM_CH-1:0];
    end
  end

  // R8
  snap_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_W'(lo_addr(0, BYTES)))
      |=> (snap_q[0] == $past(cnt_vec[0][CNT_W-1:BYTE_W])));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter #(
  parameter int NUM_CH        = 2,
  parameter int CNT_W         = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int STRETCH_TICKS = 100,
  parameter int ADDR_W        = $clog2(1 + NUM_CH * (CNT_W / 8))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] evt_in,
  input  logic              tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_n
);
  logic [NUM_CH-1:0]            evt;
  logic [NUM_CH-1:0]            fall_sel;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec;
  logic                         clr;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      evc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (evt_in[g]),
        .fall_sel (fall_sel[g]),
        .evt      (evt[g])
      );

      evc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .clr   (clr),
        .inc   (evt[g]),
        .count (cnt_vec[g])
      );

      // R4
      cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && evt[g] && cnt_vec[g] == '1) |=> (cnt_vec[g] == '0));
      // R9
      cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !evt[g]) |=> $stable(cnt_vec[g]));
      // R7
      cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_vec[g] == '0));
    end
  endgenerate

  evc_irq_stretch #(.TICKS(STRETCH_TICKS)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .trig  (|evt),
    .tick  (tick),
    .irq_n (irq_n)
  );

  evc_regif #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
    .clk      (clk),
    .rst      (rst),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .wdata    (reg_wdata),
    .cnt_vec  (cnt_vec),
    .rdata    (reg_rdata),
    .fall_sel (fall_sel),
    .clr      (clr)
  );
endmodule

// File: tb/edge_event_counter_test.sv
module edge_event_counter_test;
  localparam int TICKS = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] evt_in = 2'b00;
  logic       tick = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  wire  [7:0] reg_rdata;
  wire        irq_n;

  always #10 clk = ~clk;

  edge_event_counter uut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .tick(tick),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_q1[2], m_q2[2], m_q3[2];
  int m_cnt[2], m_snap[2], m_pol[2];
  int m_tmr = 0;
  int m_rdata = 0;

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_q1[i] = 0; m_q2[i] = 0; m_q3[i] = 0;
      m_cnt[i] = 0; m_snap[i] = 0; m_pol[i] = 0;
    end
  end

  always @(posedge clk) begin : model
    int ev[2];
    int any_ev;
    int clr;
    int r;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_q1[i] = 0; m_q2[i] = 0; m_q3[i] = 0;
        m_snap[i] = 0; m_pol[i] = 0;
      end
      m_tmr = 0;
      m_rdata = 0;
    end else begin
      any_ev = 0;
      for (int i = 0; i < 2; i++) begin
        if (m_pol[i] != 0) ev[i] = (m_q3[i] == 1 && m_q2[i] == 0) ? 1 : 0;
        else               ev[i] = (m_q3[i] == 0 && m_q2[i] == 1) ? 1 : 0;
        if (ev[i] != 0) any_ev = 1;
      end
      clr = (reg_wr && reg_addr == 3'd0 && reg_wdata[7]) ? 1 : 0;
      if (reg_rd) begin
        r = 0;
        case (reg_addr)
          3'd0: r = m_pol[0] + 2 * m_pol[1];
          3'd1: begin r = m_cnt[0] % 256; m_snap[0] = m_cnt[0] / 256; end
          3'd2: r = m_snap[0];
          3'd3: begin r = m_cnt[1] % 256; m_snap[1] = m_cnt[1] / 256; end
          3'd4: r = m_snap[1];
          default: r = 0;
        endcase
        m_rdata = r;
      end
      for (int i = 0; i < 2; i++) begin
        if (clr != 0)        m_cnt[i] = 0;
        else if (ev[i] != 0) m_cnt[i] = (m_cnt[i] + 1) % 65536;
      end
      if (reg_wr && reg_addr == 3'd0) begin
        m_pol[0] = reg_wdata[0] ? 1 : 0;
        m_pol[1] = reg_wdata[1] ? 1 : 0;
      end
      if (any_ev != 0)            m_tmr = TICKS;
      else if (tick && m_tmr > 0) m_tmr = m_tmr - 1;
      for (int i = 0; i < 2; i++) begin
        m_q3[i] = m_q2[i];
        m_q2[i] = m_q1[i];
        m_q1[i] = evt_in[i] ? 1 : 0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 irq_n vs model", int'(irq_n), (m_tmr == 0) ? 1 : 0);
      check("R11 reg_rdata vs model", int'(reg_rdata), m_rdata);
    end
  end

  // timebase: one tick every third cycle
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 3;
    tick = (tick_div == 0);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output int d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  task automatic pulse(input int ch, input int hi, input int lo);
    evt_in[ch] = 1'b1;
    cyc(hi);
    evt_in[ch] = 1'b0;
    cyc(lo);
  endtask

  task automatic toggle0(input int n);
    for (int i = 0; i < n; i++) begin
      evt_in[0] = ~evt_in[0];
      @(negedge clk);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int d;
    cyc(4);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_n after reset", int'(irq_n), 1);
    check("R1 rdata after reset", int'(reg_rdata), 0);
    rd_reg(3'd0, d); check("R1 polarity after reset", d, 0);

    // R7 clear establishes known counts
    wr_reg(3'd0, 8'h80);
    rd_reg(3'd1, d); check("R7 ch0 cleared", d, 0);
    rd_reg(3'd3, d); check("R7 ch1 cleared", d, 0);

    // R2 rising edges on channel 0
    repeat (3) pulse(0, 4, 4);
    cyc(4);
    rd_reg(3'd1, d); check("R2 ch0 low after 3 rising", d, 3);
    rd_reg(3'd2, d); check("R2 ch0 high", d, 0);
    check("R5 irq low after events", int'(irq_n), 0);

    // R3 falling polarity on channel 1, R10 independence
    wr_reg(3'd0, 8'h02);
    rd_reg(3'd0, d); check("R3 control readback", d, 2);
    repeat (2) pulse(1, 4, 4);
    cyc(4);
    rd_reg(3'd3, d); check("R3 ch1 falling count", d, 2);
    rd_reg(3'd1, d); check("R10 ch0 untouched", d, 3);

    // R5 release after stretch
    cyc(320);
    check("R5 irq released", int'(irq_n), 1);

    // R6 restart of the stretch
    pulse(0, 4, 4);
    cyc(200);
    pulse(0, 4, 4);
    cyc(150);
    check("R6 irq extended by second event", int'(irq_n), 0);
    cyc(200);
    check("R6 irq released after extension", int'(irq_n), 1);

    // R8 coherent multi-byte read
    wr_reg(3'd0, 8'h82);
    toggle0(510);
    cyc(4);
    rd_reg(3'd1, d); check("R8 low byte at FF", d, 8'hFF);
    toggle0(4);
    cyc(4);
    rd_reg(3'd2, d); check("R8 high byte from snapshot", d, 0);
    rd_reg(3'd1, d); check("R8 new low byte", d, 1);
    rd_reg(3'd2, d); check("R8 new high byte", d, 1);

    // R7 clear and edge in the same cycle
    cyc(320);
    check("R7 irq idle before collision", int'(irq_n), 1);
    evt_in[0] = 1'b1;
    cyc(2);
    reg_addr = 3'd0; reg_wdata = 8'h82; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    evt_in[0] = 1'b0;
    cyc(4);
    check("R7 edge at clear still raises irq", int'(irq_n), 0);
    rd_reg(3'd1, d); check("R7 clear wins over edge", d, 0);

    // R9 counters survive reset
    repeat (3) pulse(1, 4, 4);
    cyc(4);
    @(negedge clk); rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    rd_reg(3'd3, d); check("R9 ch1 kept over reset", d, 3);
    rd_reg(3'd0, d); check("R1 polarity back to rising", d, 0);
    rd_reg(3'd7, d); check("R11 unmapped address", d, 0);

    // R4 wrap
    wr_reg(3'd0, 8'h80);
    toggle0(131070);
    cyc(4);
    rd_reg(3'd1, d); check("R4 low byte at max", d, 8'hFF);
    rd_reg(3'd2, d); check("R4 high byte at max", d, 8'hFF);
    pulse(0, 2, 4);
    rd_reg(3'd1, d); check("R4 low byte wrapped", d, 0);
    rd_reg(3'd2, d); check("R4 high byte wrapped", d, 0);

    report();
  end
endmodule